// File: doc/BRIEF.md
# SPI Flash Transfer Engine

This block is a register-programmed SPI master for NOR flash in direct command mode. Software fills a 64-byte data buffer through a 32-bit register port. It then sets the bit count, the chip-select hold option, the clock and chip-select polarities and the clock timing fields, and writes the start bit. The engine sends the buffer on MOSI, most significant bit first. Each received MISO bit overwrites the buffer bit it has just sent. When the last bit completes, the engine sets a sticky completion flag.

A long flash command is sent as a series of chunks. The hold option keeps the device selected between chunks, and the final chunk is sent with hold cleared. Only clock phase 0 with single-lane data is supported. The register port is a plain synchronous write strobe with a combinational read. Every register, buffer word included, is written in one cycle and has no flow control.

Top module: `sfc_xfer_engine`

## Requirements
- R1: After reset the start bit, completion flag, clock fields, bit count and all mode bits read 0, CS sits at its inactive level (high), and SCLK is low. The flash-window enable (0x08 bit 17), the legacy-mode bit (0x1C bit 2) and the target-mode bit (0x30 bit 30) are plain storage that reads back as written.
- R2: Buffer word w sits at byte address 0x40+4w (w = 0..15) and reads back as written while idle. Buffer byte k is bits [8(k%4)+7 : 8(k%4)] of word k/4.
- R3: A transfer sends (0x20 bits [24:17]) + 1 bits on MOSI. It starts with byte 0 and sends each byte MSB first, one bit per SCLK cycle. MOSI stays stable while SCLK is in its active phase.
- R4: The MISO bit sampled on each leading SCLK edge replaces, in the buffer, the bit just sent. Buffer bits past the bit count are unchanged.
- R5: Writing 1 to 0x00 bit 18 starts a transfer, and that bit reads 1 while busy. Completion (0x30 bit 4) is set when the last bit ends. It stays set until software writes 0 to it; writing 1 to it has no effect.
- R6: A start request while busy is ignored, and the running transfer keeps its length.
- R7: CS is asserted from the start of a transfer. At the end it is released, unless hold (0x2C bit 30) is set; then it stays asserted until a later transfer without hold ends.
- R8: 0x2C bit 23 = 1 makes CS active high. 0x1C bit 7 = 1 makes SCLK idle high. The leading edge of each bit leaves the idle level.
- R9: The clock register holds D in bits [17:12] (D = 0 acts as 1) and H in bits [11:6]. Each bit lasts D+1 clock cycles. Its active SCLK phase is the last min(H, D-1)+1 of those cycles. Bits [5:0] are stored and read back only.
- R10: Writing 1 to 0x30 bit 31 aborts at once. It releases CS, clears completion, and makes the start bit read 0. Bit 31 reads as 0.
- R11: While busy, every register write is ignored (buffer and configuration alike), except the abort bit.
- R12: The longest transfer, 256 bits, exchanges buffer bytes 0..31 in order, MSB first, and leaves bytes 32..63 untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs | output | 1 | Chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A bit index that is off by one shows at the ports on the first leading SCLK edge. The bench records the MOSI stream and catches a swapped byte or bit order in the first byte. A capture aimed at the wrong position does not show on MOSI, so it is caught by reading the buffer once the transfer ends. A phase counter with the wrong wrap or edge point changes the leading-edge spacing or the number of active cycles within the first bit. A mishandled hold or abort leaves CS at the wrong level in the cycle after the end or the abort write.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int REG_AW = 7;
  // register byte offsets; software depends on them
  localparam logic [REG_AW-1:0] OFS_CMD   = 7'h00;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 7'h08;
  localparam logic [REG_AW-1:0] OFS_CLK   = 7'h18;
  localparam logic [REG_AW-1:0] OFS_USER  = 7'h1C;
  localparam logic [REG_AW-1:0] OFS_USER1 = 7'h20;
  localparam logic [REG_AW-1:0] OFS_USER4 = 7'h2C;
  localparam logic [REG_AW-1:0] OFS_SLAVE = 7'h30;
  localparam logic [REG_AW-1:0] OFS_DATA  = 7'h40;
  // bit positions
  localparam int B_START  = 18;
  localparam int B_WIN    = 17;
  localparam int B_CPOL   = 7;
  localparam int B_LEGACY = 2;
  localparam int B_LEN    = 17;
  localparam int B_HOLD   = 30;
  localparam int B_CSPOL  = 23;
  localparam int B_DONE   = 4;
  localparam int B_ABORT  = 31;
  localparam int B_TGT    = 30;
  localparam int F_DIV    = 12;
  localparam int F_HI     = 6;
  localparam int F_LO     = 0;
endpackage

// File: rtl/sfc_sclk_gen.sv
module sfc_sclk_gen #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] div,
  input  logic [CNT_W-1:0] hi,
  output logic             sclk_act,
  output logic             sample_now,
  output logic             bit_end
);
  logic [CNT_W-1:0] cnt_q, d_eff, mid, lead;

  // per-bit phase: idle level first, then mid+1 active cycles
  always_comb begin
    d_eff = (div == '0) ? CNT_W'(1) : div;
    mid   = (hi >= d_eff) ? d_eff - 1'b1 : hi;
    lead  = d_eff - mid;
  end

  assign sclk_act   = run && (cnt_q >= lead);
  assign sample_now = run && (cnt_q == lead - 1'b1);
  assign bit_end    = run && (cnt_q == d_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || bit_end)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sfc_shift_seq.sv
module sfc_shift_seq #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             bit_end,
  input  logic             hold,
  input  logic [LEN_W-1:0] nbits_m1,
  output logic             busy,
  output logic [LEN_W-1:0] idx,
  output logic             cs_sel,
  output logic             last_done,
  output logic             adv
);
  assign last_done = busy && bit_end && (idx == nbits_m1);
  assign adv       = busy && bit_end && (idx != nbits_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; cs_sel <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0; idx <= '0; cs_sel <= 1'b0;
    end else if (start && !busy) begin
      busy <= 1'b1; idx <= '0; cs_sel <= 1'b1;
    end else if (last_done) begin
      busy <= 1'b0; cs_sel <= hold;
    end else if (adv) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/sfc_xfer_engine.sv
module sfc_xfer_engine
  import sfc_pkg::*;
#(
  parameter int BUF_WORDS = 16,
  parameter int CNT_W     = 6,
  parameter int LEN_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_cs,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int WIX_W    = $clog2(BUF_WORDS);
  localparam int BUF_BITS = BUF_WORDS * 32;
  localparam int BIT_W    = WIX_W + 5;

  logic             win_q, cpol_q, legacy_q, hold_q, cspol_q, done_q, tgt_q, mosi_q;
  logic [CNT_W-1:0] div_q, hi_q, lo_q;
  logic [LEN_W-1:0] nbits_q, idx;
  logic [BUF_BITS-1:0] dbuf_q;
  logic busy, cs_sel, last_done, adv, sclk_act, sample_now, bit_end;

  logic is_data, cfg_we, wr_slv, start_req, start_go, abort;
  logic [WIX_W-1:0] widx;

  assign is_data   = reg_addr >= OFS_DATA;
  assign widx      = WIX_W'((reg_addr - OFS_DATA) >> 2);
  assign cfg_we    = reg_we && !busy;
  assign wr_slv    = reg_we && (reg_addr == OFS_SLAVE);
  assign abort     = wr_slv && reg_wdata[B_ABORT];
  assign start_req = reg_we && (reg_addr == OFS_CMD) && reg_wdata[B_START];
  assign start_go  = start_req && !busy && !abort;

  // buffer position of transfer bit i: byte i/8, MSB first
  function automatic logic [BIT_W-1:0] bitpos(input logic [LEN_W-1:0] i);
    bitpos = BIT_W'({i[LEN_W-1:3], ~i[2:0]});
  endfunction

  sfc_sclk_gen #(.CNT_W(CNT_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .hi(hi_q),
    .sclk_act(sclk_act), .sample_now(sample_now), .bit_end(bit_end));

  sfc_shift_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_go), .abort(abort),
    .bit_end(bit_end), .hold(hold_q), .nbits_m1(nbits_q), .busy(busy),
    .idx(idx), .cs_sel(cs_sel), .last_done(last_done), .adv(adv));

  // configuration registers, frozen while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0; cpol_q <= 1'b0; legacy_q <= 1'b0; hold_q <= 1'b0;
      cspol_q <= 1'b0; tgt_q <= 1'b0; nbits_q <= '0;
      div_q <= '0; hi_q <= '0; lo_q <= '0;
    end else if (cfg_we) begin
      case (reg_addr)
        OFS_CTRL:  win_q <= reg_wdata[B_WIN];
        OFS_CLK: begin
          div_q <= reg_wdata[F_DIV +: CNT_W];
          hi_q  <= reg_wdata[F_HI +: CNT_W];
          lo_q  <= reg_wdata[F_LO +: CNT_W];
        end
        OFS_USER: begin
          cpol_q   <= reg_wdata[B_CPOL];
          legacy_q <= reg_wdata[B_LEGACY];
        end
        OFS_USER1: nbits_q <= reg_wdata[B_LEN +: LEN_W];
        OFS_USER4: begin
          hold_q  <= reg_wdata[B_HOLD];
          cspol_q <= reg_wdata[B_CSPOL];
        end
        OFS_SLAVE: tgt_q <= reg_wdata[B_TGT];
        default: ;
      endcase
    end
  end

  // sticky completion flag: set by engine, cleared by writing 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                done_q <= 1'b0;
    else if (abort)            done_q <= 1'b0;
    else if (last_done)        done_q <= 1'b1;
    else if (wr_slv && !busy)  done_q <= done_q & reg_wdata[B_DONE];
  end

  // shared transmit/receive buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   dbuf_q <= '0;
    else if (cfg_we && is_data)   dbuf_q[{widx, 5'd0} +: 32] <= reg_wdata;
    else if (sample_now && busy)  dbuf_q[bitpos(idx)] <= spi_miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mosi_q <= 1'b0;
    else if (start_go) mosi_q <= dbuf_q[bitpos('0)];
    else if (adv)      mosi_q <= dbuf_q[bitpos(idx + 1'b1)];
  end

  always_comb begin
    reg_rdata = '0;
    if (is_data) reg_rdata = dbuf_q[{widx, 5'd0} +: 32];
    else begin
      case (reg_addr)
        OFS_CMD:   reg_rdata[B_START] = busy;
        OFS_CTRL:  reg_rdata[B_WIN] = win_q;
        OFS_CLK: begin
          reg_rdata[F_DIV +: CNT_W] = div_q;
          reg_rdata[F_HI +: CNT_W]  = hi_q;
          reg_rdata[F_LO +: CNT_W]  = lo_q;
        end
        OFS_USER: begin
          reg_rdata[B_CPOL]   = cpol_q;
          reg_rdata[B_LEGACY] = legacy_q;
        end
        OFS_USER1: reg_rdata[B_LEN +: LEN_W] = nbits_q;
        OFS_USER4: begin
          reg_rdata[B_HOLD]  = hold_q;
          reg_rdata[B_CSPOL] = cspol_q;
        end
        OFS_SLAVE: begin
          reg_rdata[B_TGT]  = tgt_q;
          reg_rdata[B_DONE] = done_q;
        end
        default: ;
      endcase
    end
  end

  assign spi_sclk = cpol_q ^ sclk_act;
  assign spi_cs   = cspol_q ? cs_sel : !cs_sel;
  assign spi_mosi = mosi_q;
endmodule

// File: rtl/sfc_xfer_engine_chk.sv
module sfc_xfer_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic last_done,
  input logic abort,
  input logic start_req,
  input logic sclk_act,
  input logic cpol,
  input logic cspol,
  input logic done,
  input logic spi_sclk,
  input logic spi_cs,
  input logic spi_mosi
);
  assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sclk_act && $past(sclk_act)) |-> $stable(spi_mosi));

  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  assert_restart_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !abort && !last_done) |=> busy);

  assert_cs_active_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (spi_cs == cspol));

  assert_idle_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == cpol));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done && (spi_cs == !cspol)));
endmodule

bind sfc_xfer_engine sfc_xfer_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .last_done(last_done),
  .abort(abort), .start_req(start_req), .sclk_act(sclk_act),
  .cpol(cpol_q), .cspol(cspol_q), .done(done_q),
  .spi_sclk(spi_sclk), .spi_cs(spi_cs), .spi_mosi(spi_mosi));

// File: tb/sfc_xfer_engine_tb_top.sv
module sfc_xfer_engine_tb_top;
  import sfc_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire spi_sclk, spi_cs, spi_mosi, spi_miso;

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] img [16];

  // serial monitor and target model
  bit mon_cpol = 1'b0, pat_mode = 1'b0, prev_act = 1'b0, cs_at_lead = 1'b0;
  int lead_n = 0, act_n = 0, cyc = 0, last_stamp = 0, per_bad = 0, exp_per = 2, ptr = 0;
  bit [255:0] tx_seen, pat;

  assign spi_miso = pat_mode ? pat[ptr & 255] : ~spi_mosi;

  always @(negedge clk) begin
    bit act;
    act = spi_sclk ^ mon_cpol;
    cyc++;
    if (act) act_n++;
    if (act && !prev_act) begin
      if (lead_n < 256) tx_seen[lead_n] = spi_mosi;
      if (lead_n > 0 && (cyc - last_stamp) != exp_per) per_bad++;
      last_stamp = cyc;
      cs_at_lead = spi_cs;
      lead_n++;
    end
    if (!act && prev_act) ptr++;
    prev_act = act;
  end

  sfc_xfer_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs(spi_cs), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    #2 reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mon_clear();
    @(negedge clk);
    #1;
    lead_n = 0; act_n = 0; per_bad = 0; ptr = 0;
    prev_act = spi_sclk ^ mon_cpol;
  endtask

  task automatic cfg(input int d, input int h, input int l, input bit cp, input bit csp, input bit hold);
    wr(OFS_CLK, (32'(d) << F_DIV) | (32'(h) << F_HI) | (32'(l) << F_LO));
    wr(OFS_USER, 32'(cp) << B_CPOL);
    wr(OFS_USER4, (32'(hold) << B_HOLD) | (32'(csp) << B_CSPOL));
    mon_cpol = cp;
    exp_per = ((d == 0) ? 1 : d) + 1;
  endtask

  task automatic start(input int nbits_m1);
    wr(OFS_SLAVE, 32'h0);
    wr(OFS_USER1, 32'(nbits_m1) << B_LEN);
    mon_clear();
    wr(OFS_CMD, 32'h1 << B_START);
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(OFS_SLAVE, v);
      if (v[B_DONE]) return;
    end
    chk({req, " completion timeout"}, 32'h0, 32'h1);
  endtask

  function automatic bit img_bit(input int i);
    int by;
    by = i / 8;
    return img[by / 4][(by % 4) * 8 + 7 - (i % 8)];
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(OFS_CMD, v);   chk("R1 start bit", v, 32'h0);
    rd(OFS_CLK, v);   chk("R1 clock reg", v, 32'h0);
    rd(OFS_SLAVE, v); chk("R1 status reg", v, 32'h0);
    chk("R1 cs idle", 32'(spi_cs), 32'h1);
    chk("R1 sclk idle", 32'(spi_sclk), 32'h0);
    wr(OFS_CTRL, 32'h1 << B_WIN);
    rd(OFS_CTRL, v);  chk("R1 window bit", v, 32'h1 << B_WIN);
    wr(OFS_CTRL, 32'h0);
  endtask

  task automatic t_buffer();
    logic [31:0] v;
    int errs = 0;
    for (int w = 0; w < 16; w++) begin
      img[w] = 32'h9E3779B9 * (w + 1);
      wr(OFS_DATA + 7'(4 * w), img[w]);
    end
    for (int w = 0; w < 16; w++) begin
      rd(OFS_DATA + 7'(4 * w), v);
      if (v !== img[w]) errs++;
    end
    chk("R2 buffer readback errors", 32'(errs), 32'h0);
    rd(OFS_DATA + 7'd60, v);
    chk("R2 last word", v, img[15]);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int errs = 0;
    cfg(3, 1, 3, 1'b0, 1'b0, 1'b0);
    img[0] = 32'h0000A5C3;
    wr(OFS_DATA, img[0]);
    start(15);
    rd(OFS_CMD, v); chk("R5 start bit while busy", v, 32'h1 << B_START);
    wait_done("R5");
    chk("R3 leading edges", 32'(lead_n), 32'd16);
    for (int i = 0; i < 16; i++) if (tx_seen[i] != img_bit(i)) errs++;
    chk("R3 mosi order errors", 32'(errs), 32'h0);
    img[0] = img[0] ^ 32'h0000FFFF;
    rd(OFS_DATA, v);        chk("R4 captured word0", v, img[0]);
    rd(OFS_DATA + 7'd4, v); chk("R4 word1 untouched", v, img[1]);
    chk("R9 period", 32'(per_bad), 32'h0);
    chk("R9 active cycles", 32'(act_n), 32'd32);
    chk("R7 cs released", 32'(spi_cs), 32'h1);
    rd(OFS_CMD, v);   chk("R5 start bit after end", v, 32'h0);
    wr(OFS_SLAVE, 32'h1 << B_DONE);
    rd(OFS_SLAVE, v); chk("R5 write 1 keeps done", v, 32'h1 << B_DONE);
    wr(OFS_SLAVE, 32'h0);
    rd(OFS_SLAVE, v); chk("R5 done cleared", v, 32'h0);
  endtask

  task automatic t_hold();
    cfg(1, 0, 1, 1'b1, 1'b1, 1'b1);
    start(7);
    wait_done("R7");
    img[0] = img[0] ^ 32'hFF;
    chk("R7 cs held after hold chunk", 32'(spi_cs), 32'h1);
    chk("R8 cs active high during run", 32'(cs_at_lead), 32'h1);
    chk("R8 sclk idles high", 32'(spi_sclk), 32'h1);
    chk("R8 edges with cpol high", 32'(lead_n), 32'd8);
    cfg(1, 0, 1, 1'b1, 1'b1, 1'b0);
    start(7);
    wait_done("R7");
    img[0] = img[0] ^ 32'hFF;
    chk("R7 cs released after final chunk", 32'(spi_cs), 32'h0);
    cfg(1, 0, 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    cfg(3, 1, 3, 1'b0, 1'b0, 1'b0);
    start(15);
    wr(OFS_CMD, 32'h1 << B_START);
    wr(OFS_DATA, 32'hDEADBEEF);
    wr(OFS_CLK, 32'h0);
    rd(OFS_CLK, v);
    chk("R11 clock write ignored", v, (32'd3 << F_DIV) | (32'd1 << F_HI) | 32'd3);
    wait_done("R6");
    chk("R6 length unchanged", 32'(lead_n), 32'd16);
    img[0] = img[0] ^ 32'h0000FFFF;
    rd(OFS_DATA, v); chk("R11 buffer write ignored", v, img[0]);
  endtask

  task automatic t_clamp();
    cfg(2, 5, 2, 1'b0, 1'b0, 1'b0);
    start(7);
    wait_done("R9");
    img[0] = img[0] ^ 32'hFF;
    chk("R9 clamped period", 32'(per_bad), 32'h0);
    chk("R9 clamped active", 32'(act_n), 32'd16);
    cfg(0, 0, 0, 1'b0, 1'b0, 1'b0);
    start(7);
    wait_done("R9");
    img[0] = img[0] ^ 32'hFF;
    chk("R9 zero divider period", 32'(per_bad), 32'h0);
    chk("R9 zero divider active", 32'(act_n), 32'd8);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int n0;
    cfg(3, 1, 3, 1'b0, 1'b0, 1'b0);
    start(255);
    repeat (10) @(negedge clk);
    wr(OFS_SLAVE, 32'h1 << B_ABORT);
    rd(OFS_CMD, v);   chk("R10 not busy", v, 32'h0);
    chk("R10 cs released", 32'(spi_cs), 32'h1);
    rd(OFS_SLAVE, v); chk("R10 status cleared", v, 32'h0);
    n0 = lead_n;
    repeat (20) @(negedge clk);
    chk("R10 clock stopped", 32'(lead_n), 32'(n0));
  endtask

  task automatic t_full();
    logic [31:0] v;
    logic [31:0] expw [16];
    int errs = 0, terr = 0;
    cfg(1, 0, 1, 1'b0, 1'b0, 1'b0);
    for (int w = 0; w < 16; w++) begin
      img[w] = 32'h5A5A0000 ^ (32'h01010101 * (w + 3));
      wr(OFS_DATA + 7'(4 * w), img[w]);
      expw[w] = img[w];
    end
    for (int i = 0; i < 256; i++) begin
      int by;
      pat[i] = 1'(((i * 5) >> 1) ^ (i >> 3));
      by = i / 8;
      expw[by / 4][(by % 4) * 8 + 7 - (i % 8)] = pat[i];
    end
    pat_mode = 1'b1;
    start(255);
    wait_done("R12");
    pat_mode = 1'b0;
    chk("R12 leading edges", 32'(lead_n), 32'd256);
    for (int i = 0; i < 256; i++) if (tx_seen[i] != img_bit(i)) terr++;
    chk("R3 full-length mosi errors", 32'(terr), 32'h0);
    for (int w = 0; w < 16; w++) begin
      rd(OFS_DATA + 7'(4 * w), v);
      if (v !== expw[w]) errs++;
    end
    chk("R12 received buffer errors", 32'(errs), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_buffer();
    t_basic();
    t_hold();
    t_busy();
    t_clamp();
    t_abort();
    t_full();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule